// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block collects three interrupt causes from a graphics engine: binner memory exhaustion, binner flush completion and render frame completion. It holds them in a pending register and drives one registered interrupt line toward the host. Software reads the pending bits and acknowledges them by writing ones. It enables causes through a set-only register and disables them through a clear-only register. Reading either of these two registers returns the current enable mask.

The two completion causes arrive as single-cycle pulses. Once acknowledged, they stay clear. The memory-exhaustion cause is also a pulse, but it leaves the engine in a starved state. While the engine is starved, the pending bit comes back even after it is acknowledged. The starved state ends when software writes a length for a new overflow buffer. The block keeps the overflow base and length registers and drives both to the engine.

Top module: `irqc_top`

## Requirements
- R1: After reset, the pending bits, the enable mask, `irq` and `rdata` are all zero.
- R2: Pending bits sit at word address 0: bit 0 is memory exhaustion, bit 1 is binner flush done, bit 2 is render done. A pulse on an event input sets its bit at the next clock edge, whether or not that cause is enabled.
- R3: A write to address 0 clears each pending bit whose `wdata` bit is 1. Bits written as 0 are left unchanged. One write may clear all three.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends set.
- R5: A write to address 1 enables each cause whose `wdata` bit is 1. Zero bits leave the mask unchanged.
- R6: A write to address 2 disables each cause whose `wdata` bit is 1. Zero bits leave the mask unchanged.
- R7: Reads of address 1 and of address 2 both return the enable mask in bits 2:0, with the upper bits zero.
- R8: `irq` is a register. It is high exactly when some pending bit is enabled, and it follows the pending and enable values that the same clock edge loads.
- R9: A memory-exhaustion pulse makes the engine starved. While it is starved, clearing bit 0 has no effect. After a write to address 4, clearing bit 0 succeeds. The two completion bits stay clear once cleared.
- R10: Address 3 holds the overflow base and address 4 holds the overflow length. Each is readable and drives `ovf_base` or `ovf_len`.
- R11: `rdata` updates at the clock edge that samples `rd_en`, and holds otherwise. Addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| evt_oom | input | 1 | Binner memory-exhaustion pulse |
| evt_bin_done | input | 1 | Binner flush-done pulse |
| evt_rend_done | input | 1 | Render frame-done pulse |
| irq | output | 1 | Registered interrupt request |
| ovf_base | output | DATA_W | Overflow buffer base to engine |
| ovf_len | output | DATA_W | Overflow buffer length to engine |

## Verification
The hardest situations to reach are the ones where the order of events matters. One is an acknowledge that lands in the same cycle as a new event on that bit. The other is an acknowledge of memory exhaustion issued before and after the new buffer length is written. The stimulus drives the event input and the clearing write on the same falling edge, so both reach the design at one rising edge. It then acknowledges bit 0 twice, once with the starved state still active and once after the length write. Each time it reads the pending register and the interrupt line back.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NSRC     = 3;
    localparam int SRC_OOM  = 0;
    localparam int SRC_BIN  = 1;
    localparam int SRC_REND = 2;

    // word addresses of the register file
    localparam int RA_STAT  = 0;
    localparam int RA_ENSET = 1;
    localparam int RA_ENCLR = 2;
    localparam int RA_OVBAS = 3;
    localparam int RA_OVLEN = 4;

    // sources whose cause is held until software repairs it
    localparam logic [NSRC-1:0] LEVEL_MASK = NSRC'(1) << SRC_OOM;
endpackage

// File: rtl/irqc_status.sv
module irqc_status #(
    parameter int              NSRC       = 3,
    parameter logic [NSRC-1:0] LEVEL_MASK = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic [NSRC-1:0] hold,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] stat_q,
    output logic [NSRC-1:0] stat_d
);
    typedef struct packed {
        logic [NSRC-1:0] pend;
    } st_t;

    st_t st_d, st_q;
    logic [NSRC-1:0] kill;
    logic [NSRC-1:0] bit_nxt;

    assign kill = clr_we ? clr_mask : '0;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        if (LEVEL_MASK[i]) begin : g_level
            assign bit_nxt[i] = evt[i] | hold[i] | (st_q.pend[i] & ~kill[i]);
        end else begin : g_pulse
            assign bit_nxt[i] = evt[i] | (st_q.pend[i] & ~kill[i]);
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.pend = bit_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_q = st_q.pend;
    assign stat_d = st_d.pend;
endmodule

// File: rtl/irqc_enable.sv
module irqc_enable #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_we,
    input  logic            clr_we,
    input  logic [NSRC-1:0] mask,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] en_d
);
    typedef struct packed {
        logic [NSRC-1:0] en;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_we)      st_d.en = st_q.en | mask;
        else if (clr_we) st_d.en = st_q.en & ~mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q = st_q.en;
    assign en_d = st_d.en;
endmodule

// File: rtl/irqc_ovfl.sv
module irqc_ovfl #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic              len_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              oom_evt,
    output logic [DATA_W-1:0] base_q,
    output logic [DATA_W-1:0] len_q,
    output logic              starved_q
);
    typedef struct packed {
        logic [DATA_W-1:0] base;
        logic [DATA_W-1:0] len;
        logic              starved;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (base_we) st_d.base = wdata;
        if (len_we)  st_d.len  = wdata;
        // a fresh exhaustion outranks a buffer handed over in the same cycle
        if (oom_evt)     st_d.starved = 1'b1;
        else if (len_we) st_d.starved = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_q    = st_q.base;
    assign len_q     = st_q.len;
    assign starved_q = st_q.starved;
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              evt_oom,
    input  logic              evt_bin_done,
    input  logic              evt_rend_done,
    output logic              irq,
    output logic [DATA_W-1:0] ovf_base,
    output logic [DATA_W-1:0] ovf_len
);
    import irqc_pkg::*;

    typedef struct packed {
        logic              irq;
        logic [DATA_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    logic            hit_stat, hit_enset, hit_enclr, hit_ovbas, hit_ovlen;
    logic [NSRC-1:0] evt_vec, hold_vec;
    logic [NSRC-1:0] stat_q, stat_d, en_q, en_d;
    logic            starved_q;

    assign hit_stat  = wr_en && (addr == ADDR_W'(RA_STAT));
    assign hit_enset = wr_en && (addr == ADDR_W'(RA_ENSET));
    assign hit_enclr = wr_en && (addr == ADDR_W'(RA_ENCLR));
    assign hit_ovbas = wr_en && (addr == ADDR_W'(RA_OVBAS));
    assign hit_ovlen = wr_en && (addr == ADDR_W'(RA_OVLEN));

    always_comb begin
        evt_vec            = '0;
        evt_vec[SRC_OOM]   = evt_oom;
        evt_vec[SRC_BIN]   = evt_bin_done;
        evt_vec[SRC_REND]  = evt_rend_done;
        hold_vec           = '0;
        hold_vec[SRC_OOM]  = starved_q;
    end

    irqc_status #(.NSRC(NSRC), .LEVEL_MASK(LEVEL_MASK)) u_stat (
        .clk(clk), .rst_n(rst_n), .evt(evt_vec), .hold(hold_vec),
        .clr_we(hit_stat), .clr_mask(wdata[NSRC-1:0]),
        .stat_q(stat_q), .stat_d(stat_d)
    );

    irqc_enable #(.NSRC(NSRC)) u_en (
        .clk(clk), .rst_n(rst_n), .set_we(hit_enset), .clr_we(hit_enclr),
        .mask(wdata[NSRC-1:0]), .en_q(en_q), .en_d(en_d)
    );

    irqc_ovfl #(.DATA_W(DATA_W)) u_ovf (
        .clk(clk), .rst_n(rst_n), .base_we(hit_ovbas), .len_we(hit_ovlen),
        .wdata(wdata), .oom_evt(evt_oom),
        .base_q(ovf_base), .len_q(ovf_len), .starved_q(starved_q)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(stat_d & en_d);
        if (rd_en) begin
            if (addr == ADDR_W'(RA_STAT))
                st_d.rdata = DATA_W'(stat_q);
            else if (addr == ADDR_W'(RA_ENSET) || addr == ADDR_W'(RA_ENCLR))
                st_d.rdata = DATA_W'(en_q);
            else if (addr == ADDR_W'(RA_OVBAS))
                st_d.rdata = ovf_base;
            else if (addr == ADDR_W'(RA_OVLEN))
                st_d.rdata = ovf_len;
            else
                st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq   = st_q.irq;
    assign rdata = st_q.rdata;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int NSRC   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              evt_bin_done,
    input logic [NSRC-1:0]   stat,
    input logic [NSRC-1:0]   en,
    input logic              starved,
    input logic              irq
);
    // R8
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(stat & en));

    // R4
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_bin_done |=> stat[1]);

    // R3
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(0) && wdata[1] && !evt_bin_done) |=> !stat[1]);

    // R9
    oom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        starved |=> stat[0]);

    // R5
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(1)) |=> ((en & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));

    // R6
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(2)) |=> ((en & $past(wdata[NSRC-1:0])) == '0));
endmodule

bind irqc_top irqc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(irqc_pkg::NSRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .evt_bin_done(evt_bin_done), .stat(stat_q), .en(en_q),
    .starved(starved_q), .irq(irq)
);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, ovf_base, ovf_len;
    logic        evt_oom = 1'b0, evt_bin_done = 1'b0, evt_rend_done = 1'b0;
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    irqc_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .evt_oom(evt_oom),
        .evt_bin_done(evt_bin_done), .evt_rend_done(evt_rend_done),
        .irq(irq), .ovf_base(ovf_base), .ovf_len(ovf_len)
    );

    typedef struct packed {
        logic        rd;
        logic [2:0]  a;
        logic [31:0] d;
        logic        irq_exp;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [15] = '{
        '{1'b0, 3'd1, 32'h5,        1'b0, 4'd5},  // R5
        '{1'b1, 3'd1, 32'h5,        1'b0, 4'd7},  // R7
        '{1'b1, 3'd2, 32'h5,        1'b0, 4'd7},  // R7
        '{1'b0, 3'd1, 32'h2,        1'b0, 4'd5},  // R5
        '{1'b1, 3'd1, 32'h7,        1'b0, 4'd5},  // R5
        '{1'b0, 3'd2, 32'h1,        1'b0, 4'd6},  // R6
        '{1'b1, 3'd2, 32'h6,        1'b0, 4'd6},  // R6
        '{1'b0, 3'd2, 32'h0,        1'b0, 4'd6},  // R6
        '{1'b1, 3'd1, 32'h6,        1'b0, 4'd6},  // R6
        '{1'b0, 3'd3, 32'h12345670, 1'b0, 4'd10}, // R10
        '{1'b1, 3'd3, 32'h12345670, 1'b0, 4'd10}, // R10
        '{1'b0, 3'd4, 32'h00010000, 1'b0, 4'd10}, // R10
        '{1'b1, 3'd4, 32'h00010000, 1'b0, 4'd10}, // R10
        '{1'b1, 3'd7, 32'h0,        1'b0, 4'd11}, // R11
        '{1'b1, 3'd0, 32'h0,        1'b0, 4'd2}   // R2
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d,
                      input logic [2:0] ev = 3'b000);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        {evt_rend_done, evt_bin_done, evt_oom} = ev;
        @(negedge clk);
        wr_en = 1'b0;
        {evt_rend_done, evt_bin_done, evt_oom} = 3'b000;
    endtask

    task automatic pulse(input logic [2:0] ev);
        @(negedge clk);
        {evt_rend_done, evt_bin_done, evt_oom} = ev;
        @(negedge clk);
        {evt_rend_done, evt_bin_done, evt_oom} = 3'b000;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 rdata", rdata, 32'h0);
        rd(3'd0, v); chk("R1 status", v, 32'h0);
        rd(3'd1, v); chk("R1 enable", v, 32'h0);

        for (int i = 0; i < 15; i++) begin
            if (VECS[i].rd) begin
                rd(VECS[i].a, v);
                chk($sformatf("R%0d table row %0d", VECS[i].req, i), v, VECS[i].d);
            end else begin
                wr(VECS[i].a, VECS[i].d);
            end
            chk($sformatf("R8 irq table row %0d", i), 32'(irq), 32'(VECS[i].irq_exp));
        end
        chk("R10 ovf_base port", ovf_base, 32'h12345670);
        chk("R10 ovf_len port", ovf_len, 32'h00010000);

        // R2/R8: exhaustion latched while disabled, no irq
        pulse(3'b001);
        chk("R8 disabled source no irq", 32'(irq), 32'h0);
        rd(3'd0, v); chk("R2 oom latched", v, 32'h1);
        // R9: acknowledge while starved has no effect
        wr(3'd0, 32'h1);
        rd(3'd0, v); chk("R9 oom reasserts", v, 32'h1);
        wr(3'd1, 32'h1);
        chk("R8 irq on enable", 32'(irq), 32'h1);
        wr(3'd4, 32'h00020000);
        wr(3'd0, 32'h1);
        chk("R9 irq after repair clear", 32'(irq), 32'h0);
        rd(3'd0, v); chk("R9 oom cleared", v, 32'h0);

        // binner flush done
        pulse(3'b010);
        chk("R8 irq bin done", 32'(irq), 32'h1);
        rd(3'd0, v); chk("R2 bin latched", v, 32'h2);
        wr(3'd0, 32'h2);
        repeat (3) @(negedge clk);
        rd(3'd0, v); chk("R9 bin stays clear", v, 32'h0);
        chk("R8 irq dropped", 32'(irq), 32'h0);

        // R4: event and clear together
        wr(3'd0, 32'h4, 3'b100);
        rd(3'd0, v); chk("R4 event wins", v, 32'h4);

        // R3: zero bits ignored, then clear all
        pulse(3'b010);
        wr(3'd0, 32'h2);
        rd(3'd0, v); chk("R3 zero bits kept", v, 32'h4);
        // R8: disable with bit pending
        wr(3'd2, 32'h6);
        chk("R8 irq masked", 32'(irq), 32'h0);
        rd(3'd0, v); chk("R8 status kept while masked", v, 32'h4);
        pulse(3'b011);
        wr(3'd4, 32'h0);
        wr(3'd0, 32'h7);
        rd(3'd0, v); chk("R3 clear all", v, 32'h0);

        // R11: rdata holds without rd_en
        rd(3'd3, v);
        repeat (2) @(negedge clk);
        chk("R11 rdata hold", rdata, 32'h12345670);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule